// File: doc/BRIEF.md
# Mode-Switchable Stage-Fusing Pipeline Segment

This block is a short in-order datapath with four stages: an entry logic stage, two storage sub-stages and an exit logic stage, each followed by a register. A mode input picks one of two operating points. In performance mode all four registers clock normally. In efficiency mode the register after the first storage sub-stage turns transparent, so both storage sub-stages finish within one cycle and the segment needs one cycle less. The stage transforms are plain combinational functions that stand in for real arrays. The result value does not depend on the mode.

A mode request takes effect only when the segment is fully drained. Until then it is held. Beside the datapath, a latency tracker raises a wake pulse that lets dependent work be scheduled. The wake delay is a programmed value, clamped so that it can never be shorter than the current segment latency. The programmed delay is sampled at the same idle moments as the mode, so operations already in flight keep the delay they started with.

Top module: `fuse_pipe_seg`

## Requirements
- R1: After reset, out_vld and wake are 0 and mode_ee is 0, which means performance mode.
- R2: With the default keys (A=16'h5A3C, B=16'h0123, C=16'hF00F), each output word is ((rotl1(x ^ A)) + B) ^ C modulo 2^16, where x is the input word and rotl1 rotates left by one bit with bit 15 moving into bit 0. This holds in both modes.
- R3: In performance mode (mode_ee=0), a word presented with in_vld in cycle t appears with out_vld in cycle t+4.
- R4: In efficiency mode (mode_ee=1), a word presented in cycle t appears in cycle t+3.
- R5: Inputs on consecutive cycles give outputs on consecutive cycles, in the same order, in both modes. Every input gives exactly one output.
- R6: mode_ee follows mode_req only at a clock edge where in_vld is low, no stage holds valid data and no wake is pending. A request made while work is in flight is held until then, and mode_ee stays unchanged meanwhile.
- R7: wake pulses in cycle t+E for an input in cycle t. E is the larger of lat_cfg and the current segment latency (4 or 3). lat_cfg is captured at the same idle edges as the mode.
- R8: A wake pulse never comes before the output it belongs to. With lat_cfg below the segment latency, wake coincides with out_vld.
- R9: A change on lat_cfg while work is in flight has no effect on the wake timing of that work. The new value applies only after the segment has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_dat | input | DATA_W | Input word |
| mode_req | input | 1 | Requested mode: 0 performance, 1 efficiency |
| lat_cfg | input | LAT_W | Programmed wake latency in cycles |
| out_vld | output | 1 | Output word valid |
| out_dat | output | DATA_W | Output word |
| wake | output | 1 | Dependent-operation ready pulse |
| mode_ee | output | 1 | Mode in force: 1 when the storage sub-stages are fused |

## Verification
The latency assertions assume that in_vld is never high while reset is asserted. They also assume the mode can only change when in_vld is low, which the block itself enforces. The wake-ordering check assumes fewer than 2^32 outputs between resets. The stimulus changes lat_cfg and mode_req at arbitrary points, including mid-burst. It always lets the segment idle for at least one cycle before it expects a new setting to apply. The bench does not assume that a request made mid-burst is applied early.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic {
    MODE_HP = 1'b0,
    MODE_EE = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    XFORM_XOR  = 2'd0,
    XFORM_ROTX = 2'd1,
    XFORM_ADD  = 2'd2
  } xform_e;

  // segment latency, input valid to output valid, per mode
  localparam int LAT_HP_C = 4;
  localparam int LAT_EE_C = 3;
endpackage

// File: rtl/fuse_stage.sv
module fuse_stage
  import fuse_pkg::*;
#(
  parameter int         W    = 16,
  parameter xform_e     KIND = XFORM_XOR,
  parameter logic [W-1:0] K  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         thru,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  logic [W-1:0] f_w;
  logic         vld_q;
  logic [W-1:0] dat_q;

  generate
    if (KIND == XFORM_XOR) begin : g_xor
      assign f_w = dat_i ^ K;
    end else if (KIND == XFORM_ROTX) begin : g_rot
      assign f_w = {dat_i[W-2:0], dat_i[W-1]} ^ K;
    end else begin : g_add
      assign f_w = dat_i + K;
    end
  endgenerate

  // register holds still while transparent
  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (!thru) vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (!thru && vld_i) dat_q <= f_w;
  end

  assign vld_o = thru ? vld_i : vld_q;
  assign dat_o = thru ? f_w   : dat_q;

  // R6: a bypassed register was emptied before the switch and stays empty
  thru_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    thru |-> !vld_q);
endmodule

// File: rtl/fuse_mode_ctl.sv
module fuse_mode_ctl
  import fuse_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             mode_req,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             mode_ee,
  output logic [LAT_W-1:0] eff_lat
);
  localparam logic [LAT_W-1:0] FLOOR_HP = LAT_W'(LAT_HP_C);
  localparam logic [LAT_W-1:0] FLOOR_EE = LAT_W'(LAT_EE_C);

  mode_e            mode_q;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] floor_w;

  assign floor_w = mode_req ? FLOOR_EE : FLOOR_HP;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_HP;
      lat_q  <= FLOOR_HP;
    end else if (idle) begin
      mode_q <= mode_req ? MODE_EE : MODE_HP;
      lat_q  <= (lat_cfg > floor_w) ? lat_cfg : floor_w;
    end
  end

  assign mode_ee = (mode_q == MODE_EE);
  assign eff_lat = lat_q;

  // R6
  mode_chg_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(idle));

  // R8
  lat_floor_chk: assert property (@(posedge clk) disable iff (rst)
    eff_lat >= (mode_ee ? FLOOR_EE : FLOOR_HP));

  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_q != $past(lat_q)) |-> $past(idle));
endmodule

// File: rtl/fuse_lat_track.sv
module fuse_lat_track #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [LAT_W-1:0] eff_lat,
  output logic             wake,
  output logic             busy
);
  localparam int HIST_D = 1 << LAT_W;

  logic [HIST_D-1:0] hist_q;
  logic [LAT_W-1:0]  tap_w;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[HIST_D-2:0], issue};
  end

  assign tap_w = eff_lat - 1'b1;
  assign wake  = hist_q[tap_w];
  assign busy  = |hist_q;
endmodule

// File: rtl/fuse_pipe_seg.sv
module fuse_pipe_seg
  import fuse_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                LAT_W  = 4,
  parameter logic [DATA_W-1:0] KEY_A  = 16'h5A3C,
  parameter logic [DATA_W-1:0] KEY_B  = 16'h0123,
  parameter logic [DATA_W-1:0] KEY_C  = 16'hF00F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  input  logic              mode_req,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_dat,
  output logic              wake,
  output logic              mode_ee
);
  logic              v1, v2a, v2b;
  logic [DATA_W-1:0] d1, d2a, d2b;
  logic              trk_busy;
  logic              idle_w;
  logic [LAT_W-1:0]  eff_lat;

  assign idle_w = !(in_vld | v1 | v2a | v2b | out_vld | trk_busy);

  fuse_mode_ctl #(.LAT_W(LAT_W)) u_ctl (
    .clk(clk), .rst(rst), .idle(idle_w), .mode_req(mode_req),
    .lat_cfg(lat_cfg), .mode_ee(mode_ee), .eff_lat(eff_lat)
  );

  fuse_stage #(.W(DATA_W), .KIND(XFORM_XOR), .K(KEY_A)) u_s1 (
    .clk(clk), .rst(rst), .thru(1'b0), .vld_i(in_vld), .dat_i(in_dat),
    .vld_o(v1), .dat_o(d1)
  );

  // the fusable register: transparent in efficiency mode
  fuse_stage #(.W(DATA_W), .KIND(XFORM_ROTX), .K('0)) u_s2a (
    .clk(clk), .rst(rst), .thru(mode_ee), .vld_i(v1), .dat_i(d1),
    .vld_o(v2a), .dat_o(d2a)
  );

  fuse_stage #(.W(DATA_W), .KIND(XFORM_ADD), .K(KEY_B)) u_s2b (
    .clk(clk), .rst(rst), .thru(1'b0), .vld_i(v2a), .dat_i(d2a),
    .vld_o(v2b), .dat_o(d2b)
  );

  fuse_stage #(.W(DATA_W), .KIND(XFORM_XOR), .K(KEY_C)) u_s3 (
    .clk(clk), .rst(rst), .thru(1'b0), .vld_i(v2b), .dat_i(d2b),
    .vld_o(out_vld), .dat_o(out_dat)
  );

  fuse_lat_track #(.LAT_W(LAT_W)) u_trk (
    .clk(clk), .rst(rst), .issue(in_vld), .eff_lat(eff_lat),
    .wake(wake), .busy(trk_busy)
  );

  // checker-side counts for wake ordering
  logic [31:0] out_cnt_q, wake_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt_q  <= '0;
      wake_cnt_q <= '0;
    end else begin
      out_cnt_q  <= out_cnt_q + 32'(out_vld);
      wake_cnt_q <= wake_cnt_q + 32'(wake);
    end
  end

  // R3
  hp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !mode_ee) |-> ##4 out_vld);

  // R4
  ee_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode_ee) |-> ##3 out_vld);

  // R8
  wake_order_chk: assert property (@(posedge clk) disable iff (rst)
    (33'(wake_cnt_q) + 33'(wake)) <= (33'(out_cnt_q) + 33'(out_vld)));
endmodule

// File: tb/sim_fuse_pipe_seg.sv
`timescale 1ns/1ps
module sim_fuse_pipe_seg;
  localparam int                W  = 16;
  localparam int                LW = 4;
  localparam logic [W-1:0]      KA = 16'h5A3C;
  localparam logic [W-1:0]      KB = 16'h0123;
  localparam logic [W-1:0]      KC = 16'hF00F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [W-1:0] in_dat = '0;
  logic mode_req = 1'b0;
  logic [LW-1:0] lat_cfg = '0;
  logic out_vld, wake, mode_ee;
  logic [W-1:0] out_dat;

  always #2.5 clk = ~clk;

  fuse_pipe_seg #(.DATA_W(W), .LAT_W(LW), .KEY_A(KA), .KEY_B(KB), .KEY_C(KC)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_dat(in_dat), .mode_req(mode_req),
    .lat_cfg(lat_cfg), .out_vld(out_vld), .out_dat(out_dat), .wake(wake),
    .mode_ee(mode_ee)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int outs_seen = 0;
  int wakes_seen = 0;
  bit exp_ee = 1'b0;
  int cur_lat = 0;

  typedef struct { logic [W-1:0] d; int t; string req; } item_t;
  item_t dq[$];
  int    wq[$];

  function automatic logic [W-1:0] ref_f(logic [W-1:0] x);
    logic [W-1:0] a;
    a = x ^ KA;
    a = {a[W-2:0], a[W-1]};
    return (a + KB) ^ KC;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    item_t e;
    int    wt;
    #1;
    if (!rst) begin
      if (out_vld) begin
        outs_seen++;
        if (dq.size() == 0) chk(1'b0, "R5", "unexpected output", out_dat, 0);
        else begin
          e = dq.pop_front();
          chk(out_dat == e.d, "R2", "output word", out_dat, e.d);
          chk(cyc == e.t, e.req, "output cycle", cyc, e.t);
        end
      end
      if (wake) begin
        wakes_seen++;
        chk(wakes_seen <= outs_seen, "R8", "wake before output", wakes_seen, outs_seen);
        if (wq.size() == 0) chk(1'b0, "R7", "unexpected wake", cyc, 0);
        else begin
          wt = wq.pop_front();
          chk(cyc == wt, "R7", "wake cycle", cyc, wt);
        end
      end
    end
  end

  // driver: n back-to-back words; at index chg, lat_cfg and mode_req change
  task automatic send(int n, logic [W-1:0] seed, int chg, int lat_new, bit mode_new);
    int l, e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(mode_ee == exp_ee, "R6", "mode held while busy", mode_ee, exp_ee);
      if (i == chg) begin
        lat_cfg  = LW'(lat_new);
        mode_req = mode_new;
      end
      l = exp_ee ? 3 : 4;
      e = (cur_lat > l) ? cur_lat : l;
      in_vld = 1'b1;
      in_dat = seed + W'(i * 16'h1357);
      dq.push_back('{ref_f(in_dat), cyc + l, exp_ee ? "R4" : "R3"});
      wq.push_back(cyc + e);
    end
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic drain();
    repeat (22) @(negedge clk);
  endtask

  task automatic set_lat(int v);
    @(negedge clk);
    lat_cfg = LW'(v);
    repeat (2) @(negedge clk);
    cur_lat = v;
  endtask

  task automatic go_mode(bit ee);
    @(negedge clk);
    mode_req = ee;
    repeat (2) @(negedge clk);
    exp_ee = ee;
    chk(mode_ee == ee, "R6", "mode applied when idle", mode_ee, ee);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(out_vld == 1'b0, "R1", "out_vld after reset", out_vld, 0);
    chk(wake == 1'b0, "R1", "wake after reset", wake, 0);
    chk(mode_ee == 1'b0, "R1", "mode after reset", mode_ee, 0);

    // R3 single word, R8 clamp with lat_cfg=0
    send(1, 16'h0001, -1, 0, 1'b0);
    drain();
    // R7 programmed latency
    set_lat(9);
    send(1, 16'hBEEF, -1, 0, 1'b0);
    drain();
    // R5 burst in performance mode
    set_lat(0);
    send(6, 16'h8000, -1, 0, 1'b0);
    drain();
    // R6 request efficiency mode mid-burst
    send(5, 16'h7FFF, 1, 0, 1'b1);
    drain();
    exp_ee = 1'b1;
    chk(mode_ee == 1'b1, "R6", "mode after drain", mode_ee, 1);
    // R4 single and burst in efficiency mode
    send(1, 16'hFFFF, -1, 0, 1'b1);
    drain();
    send(8, 16'h1234, -1, 0, 1'b1);
    drain();
    // R9 latency change mid-burst is ignored by in-flight work
    set_lat(7);
    send(6, 16'h0F0F, 2, 12, 1'b1);
    drain();
    cur_lat = 12;
    send(1, 16'hA5A5, -1, 12, 1'b1);
    drain();
    // back to performance mode
    set_lat(0);
    go_mode(1'b0);
    send(3, 16'hC001, -1, 0, 1'b0);
    drain();

    chk(dq.size() == 0, "R5", "outputs missing", dq.size(), 0);
    chk(wq.size() == 0, "R7", "wakes missing", wq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule